// File: doc/BRIEF.md
# Low-Power Mode and Clock Enable Controller

This block chooses the power mode of a small microcontroller and turns the CPU clock, the peripheral clock and the oscillator on or off to suit that mode. It runs from a reference clock at twice the oscillator frequency. From that clock it makes a master-rate enable: every reference cycle when the PLL option is on, and every fourth reference cycle (oscillator / 2) when it is off. When the slow bit is set, a further divide by 2, 4, 8 or 16 applies. The CPU and the peripheral clocks are single-cycle enable pulses at the selected rate, not derived clocks.

A wait-for-interrupt strobe stops the CPU and leaves the peripherals running. A halt strobe has three outcomes. If the oscillator-interrupt enable is set, it enters a stop mode that keeps the oscillator running. If that enable is clear, it enters a deep stop that turns the oscillator off. If that enable is clear and the watchdog is active with its halt option enabled, the clocks are not stopped and a watchdog reset request is raised instead. Each entry into a low-power mode forces the interrupt-mask bits so that all interrupts are enabled. Each exit raises a wake request. On exit from the deep stop, the CPU is held off for a programmable settling time.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After a synchronous reset the block is in Run: `mode` = 0, `osc_en` = 1, and `wake_req`, `wdg_rst_req` and `imask_force` are all 0.
- R2: With `slow_en` = 0, `cpu_ce` and `per_ce` pulse once every 4 reference cycles when `pll_on` = 0 and every reference cycle when `pll_on` = 1. `mode` = 0.
- R3: With `slow_en` = 1, the period from R2 is multiplied by 2, 4, 8 or 16 for `div_sel` = 00, 01, 10 or 11, and `mode` = 1 (Slow).
- R4: A `wfi` strobe in Run stops `cpu_ce`. `per_ce` keeps pulsing at the current rate. `mode` becomes 2 (Wait), or 3 (Slow-Wait) if `slow_en` = 1.
- R5: In the cycle after entry to Wait, Slow-Wait, Active-Halt or Halt, `imask_force` is high for one cycle with `imask_val` = 2'b10.
- R6: A `halt` strobe with `osc_irq_en` = 1 enters Active-Halt (`mode` = 4). `osc_en` stays 1, `cpu_ce` and `per_ce` stop, and no watchdog reset is requested even if the watchdog and its halt option are active.
- R7: A `halt` strobe with `osc_irq_en` = 0, when the watchdog-halt condition of R10 does not apply, enters Halt (`mode` = 5) with `osc_en` = 0 and both clock enables stopped.
- R8: In Halt, `rtc_tick`, `css_evt`, `irq_any` and `halt` have no effect. Only `halt_exit_irq` (or reset) leaves Halt.
- R9: After `halt_exit_irq` is sampled in Halt, `osc_en` returns to 1 at once. `mode` stays 5 and the clock enables stay low for `STAB_CYCLES` reference cycles. `wake_req` then pulses and `mode` returns to Run, which is `STAB_CYCLES`+1 cycles after the exit interrupt was sampled.
- R10: A `halt` strobe with `osc_irq_en` = 0, `wdg_active` = 1 and `wdg_halt_opt` = 1 leaves the mode at Run, keeps the clocks running, and pulses `wdg_rst_req` for one cycle.
- R11: In Wait, Slow-Wait or Active-Halt, any of `rtc_tick`, `css_evt`, `halt_exit_irq` or `irq_any` returns the block to Run in the next cycle, with a one-cycle `wake_req` pulse and no settling delay.
- R12: When `halt` and `wfi` are both asserted in Run, `halt` takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, twice the oscillator frequency |
| rst | input | 1 | Synchronous active-high reset |
| pll_on | input | 1 | PLL option: 1 gives master = 2x oscillator, 0 gives oscillator / 2 |
| slow_en | input | 1 | Slow-mode enable from the control register |
| div_sel | input | 2 | Slow divider select (00 /2, 01 /4, 10 /8, 11 /16) |
| osc_irq_en | input | 1 | Oscillator-interrupt enable; selects Active-Halt on halt |
| wfi | input | 1 | Wait-for-interrupt instruction strobe |
| halt | input | 1 | Halt instruction strobe |
| wdg_active | input | 1 | Watchdog is running |
| wdg_halt_opt | input | 1 | Watchdog option: halt produces a reset |
| rtc_tick | input | 1 | Real-time clock wake event |
| css_evt | input | 1 | Clock-security wake event |
| halt_exit_irq | input | 1 | Interrupt with exit-from-halt capability |
| irq_any | input | 1 | Any other interrupt |
| cpu_ce | output | 1 | CPU clock enable pulse |
| per_ce | output | 1 | Peripheral clock enable pulse |
| osc_en | output | 1 | Oscillator enable |
| imask_force | output | 1 | Strobe to load `imask_val` into the interrupt-mask bits |
| imask_val | output | 2 | Value forced into the interrupt-mask bits |
| wake_req | output | 1 | Wake request pulse on exit from a low-power mode |
| wdg_rst_req | output | 1 | Watchdog reset request pulse |
| mode | output | 3 | Mode: 0 Run, 1 Slow, 2 Wait, 3 Slow-Wait, 4 Active-Halt, 5 Halt |

## Verification
The assertions check relations between the outputs on every cycle. A CPU enable only ever appears in Run or Slow, and a peripheral enable never appears in a halt mode. The oscillator is off only in Halt. Mask forcing only happens in a low-power mode. Wake and watchdog requests only appear with the block back in Run. With the PLL off, enable pulses never come back to back. The exact divide ratios, the rejection of non-exit wake sources in Halt, the length of the settling wait and the priority of halt over wait can only be shown by the bench's timed scenarios.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_WAIT  = 3'd1,
    ST_AHALT = 3'd2,
    ST_HALT  = 3'd3,
    ST_STAB  = 3'd4
  } pstate_t;

  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_RUN   = 3'd0;
  localparam logic [MODE_W-1:0] MODE_SLOW  = 3'd1;
  localparam logic [MODE_W-1:0] MODE_WAIT  = 3'd2;
  localparam logic [MODE_W-1:0] MODE_SWAIT = 3'd3;
  localparam logic [MODE_W-1:0] MODE_AHALT = 3'd4;
  localparam logic [MODE_W-1:0] MODE_HALT  = 3'd5;

  localparam int IMASK_W = 2;
  localparam logic [IMASK_W-1:0] IMASK_ALL_ON = 2'b10;
endpackage

// File: rtl/pwr_clk_div.sv
module pwr_clk_div #(
  parameter int OFF_RATIO = 4,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pll_on,
  input  logic             slow_en,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int MAX_MUL = 2 << ((1 << SEL_W) - 1);
  localparam int MAX_P   = OFF_RATIO * MAX_MUL;
  localparam int CW      = $clog2(MAX_P + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] base;
  logic [CW-1:0] mul;
  logic [CW-1:0] period;

  always_comb begin
    base   = pll_on ? CW'(1) : CW'(OFF_RATIO);
    mul    = slow_en ? (CW'(2) << div_sel) : CW'(1);
    period = base * mul;
    tick   = (cnt_q >= period - CW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/pwr_stab_timer.sv
module pwr_stab_timer #(
  parameter int CYCLES = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int TW = $clog2(CYCLES + 1);

  logic          run_q;
  logic [TW-1:0] cnt_q;

  assign done = run_q && (cnt_q == TW'(CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (done) run_q <= 1'b0;
      else      cnt_q <= cnt_q + TW'(1);
    end
  end
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    wfi,
  input  logic    halt,
  input  logic    osc_irq_en,
  input  logic    wdg_active,
  input  logic    wdg_halt_opt,
  input  logic    rtc_tick,
  input  logic    css_evt,
  input  logic    halt_exit_irq,
  input  logic    irq_any,
  input  logic    stab_done,
  output pstate_t state_d,
  output logic    stab_start,
  output logic    ev_enter,
  output logic    ev_wake,
  output logic    ev_wdg
);
  pstate_t state_q;
  logic    any_wake;

  assign any_wake = rtc_tick | css_evt | halt_exit_irq | irq_any;

  always_comb begin
    state_d    = state_q;
    stab_start = 1'b0;
    ev_enter   = 1'b0;
    ev_wake    = 1'b0;
    ev_wdg     = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (halt) begin
          if (osc_irq_en) begin
            state_d  = ST_AHALT;
            ev_enter = 1'b1;
          end else if (wdg_active && wdg_halt_opt) begin
            ev_wdg = 1'b1;
          end else begin
            state_d  = ST_HALT;
            ev_enter = 1'b1;
          end
        end else if (wfi) begin
          state_d  = ST_WAIT;
          ev_enter = 1'b1;
        end
      end
      ST_WAIT, ST_AHALT: begin
        if (any_wake) begin
          state_d = ST_RUN;
          ev_wake = 1'b1;
        end
      end
      ST_HALT: begin
        if (halt_exit_irq) begin
          state_d    = ST_STAB;
          stab_start = 1'b1;
        end
      end
      ST_STAB: begin
        if (stab_done) begin
          state_d = ST_RUN;
          ev_wake = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RUN;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_pkg::*;
#(
  parameter int OFF_RATIO   = 4,
  parameter int SEL_W       = 2,
  parameter int STAB_CYCLES = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pll_on,
  input  logic             slow_en,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             osc_irq_en,
  input  logic             wfi,
  input  logic             halt,
  input  logic             wdg_active,
  input  logic             wdg_halt_opt,
  input  logic             rtc_tick,
  input  logic             css_evt,
  input  logic             halt_exit_irq,
  input  logic             irq_any,
  output logic             cpu_ce,
  output logic             per_ce,
  output logic             osc_en,
  output logic             imask_force,
  output logic [1:0]       imask_val,
  output logic             wake_req,
  output logic             wdg_rst_req,
  output logic [2:0]       mode
);
  logic              tick;
  logic              stab_start;
  logic              stab_done;
  logic              ev_enter;
  logic              ev_wake;
  logic              ev_wdg;
  pstate_t           state_d;
  logic [MODE_W-1:0] mode_c;

  pwr_clk_div #(.OFF_RATIO(OFF_RATIO), .SEL_W(SEL_W)) u_div (
    .clk(clk), .rst(rst), .pll_on(pll_on), .slow_en(slow_en),
    .div_sel(div_sel), .tick(tick)
  );

  pwr_stab_timer #(.CYCLES(STAB_CYCLES)) u_stab (
    .clk(clk), .rst(rst), .start(stab_start), .done(stab_done)
  );

  pwr_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .wfi(wfi), .halt(halt), .osc_irq_en(osc_irq_en),
    .wdg_active(wdg_active), .wdg_halt_opt(wdg_halt_opt),
    .rtc_tick(rtc_tick), .css_evt(css_evt), .halt_exit_irq(halt_exit_irq),
    .irq_any(irq_any), .stab_done(stab_done), .state_d(state_d),
    .stab_start(stab_start), .ev_enter(ev_enter), .ev_wake(ev_wake),
    .ev_wdg(ev_wdg)
  );

  always_comb begin
    unique case (state_d)
      ST_RUN:            mode_c = slow_en ? MODE_SLOW : MODE_RUN;
      ST_WAIT:           mode_c = slow_en ? MODE_SWAIT : MODE_WAIT;
      ST_AHALT:          mode_c = MODE_AHALT;
      ST_HALT, ST_STAB:  mode_c = MODE_HALT;
      default:           mode_c = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_ce      <= 1'b0;
      per_ce      <= 1'b0;
      osc_en      <= 1'b1;
      imask_force <= 1'b0;
      imask_val   <= '0;
      wake_req    <= 1'b0;
      wdg_rst_req <= 1'b0;
      mode        <= MODE_RUN;
    end else begin
      cpu_ce      <= tick && (state_d == ST_RUN);
      per_ce      <= tick && ((state_d == ST_RUN) || (state_d == ST_WAIT));
      osc_en      <= (state_d != ST_HALT);
      imask_force <= ev_enter;
      imask_val   <= ev_enter ? IMASK_ALL_ON : '0;
      wake_req    <= ev_wake;
      wdg_rst_req <= ev_wdg;
      mode        <= mode_c;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       pll_on,
  input logic       cpu_ce,
  input logic       per_ce,
  input logic       osc_en,
  input logic       imask_force,
  input logic [1:0] imask_val,
  input logic       wake_req,
  input logic       wdg_rst_req,
  input logic [2:0] mode
);
  AST_MODE_LEGAL:   assert property (@(posedge clk) disable iff (rst) mode <= 3'd5); // R1
  AST_SLOW_RATE:    assert property (@(posedge clk) disable iff (rst) (cpu_ce && !pll_on) |=> !cpu_ce); // R2
  AST_CPU_RUN_ONLY: assert property (@(posedge clk) disable iff (rst) cpu_ce |-> (mode <= 3'd1)); // R4
  AST_PER_NOT_HALT: assert property (@(posedge clk) disable iff (rst) per_ce |-> (mode <= 3'd3)); // R6
  AST_MASK_FORCE:   assert property (@(posedge clk) disable iff (rst) imask_force |-> (mode >= 3'd2 && imask_val == 2'b10)); // R5
  AST_AHALT_OSC:    assert property (@(posedge clk) disable iff (rst) (mode == 3'd4) |-> osc_en); // R6
  AST_OSC_OFF_HALT: assert property (@(posedge clk) disable iff (rst) !osc_en |-> (mode == 3'd5)); // R7
  AST_WDG_IN_RUN:   assert property (@(posedge clk) disable iff (rst) wdg_rst_req |-> (mode <= 3'd1 && osc_en)); // R10
  AST_WAKE_TO_RUN:  assert property (@(posedge clk) disable iff (rst) wake_req |-> (mode <= 3'd1 && !imask_force)); // R11
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .pll_on(pll_on), .cpu_ce(cpu_ce), .per_ce(per_ce),
  .osc_en(osc_en), .imask_force(imask_force), .imask_val(imask_val),
  .wake_req(wake_req), .wdg_rst_req(wdg_rst_req), .mode(mode)
);

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
  localparam int STAB = 256;
  localparam int WIN  = 128;

  typedef struct packed {
    logic       pll;
    logic       slow;
    logic [1:0] sel;
    logic [7:0] per;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b0, 2'd0, 8'd4},
    '{1'b1, 1'b0, 2'd0, 8'd1},
    '{1'b0, 1'b1, 2'd0, 8'd8},
    '{1'b0, 1'b1, 2'd1, 8'd16},
    '{1'b0, 1'b1, 2'd2, 8'd32},
    '{1'b0, 1'b1, 2'd3, 8'd64},
    '{1'b1, 1'b1, 2'd0, 8'd2},
    '{1'b1, 1'b1, 2'd3, 8'd16}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pll_on = 1'b0, slow_en = 1'b0, osc_irq_en = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic wfi = 1'b0, halt = 1'b0, wdg_active = 1'b0, wdg_halt_opt = 1'b0;
  logic rtc_tick = 1'b0, css_evt = 1'b0, halt_exit_irq = 1'b0, irq_any = 1'b0;
  logic cpu_ce, per_ce, osc_en, imask_force, wake_req, wdg_rst_req;
  logic [1:0] imask_val;
  logic [2:0] mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pwr_mode_ctrl #(.STAB_CYCLES(STAB)) u0 (
    .clk(clk), .rst(rst), .pll_on(pll_on), .slow_en(slow_en), .div_sel(div_sel),
    .osc_irq_en(osc_irq_en), .wfi(wfi), .halt(halt), .wdg_active(wdg_active),
    .wdg_halt_opt(wdg_halt_opt), .rtc_tick(rtc_tick), .css_evt(css_evt),
    .halt_exit_irq(halt_exit_irq), .irq_any(irq_any), .cpu_ce(cpu_ce),
    .per_ce(per_ce), .osc_en(osc_en), .imask_force(imask_force),
    .imask_val(imask_val), .wake_req(wake_req), .wdg_rst_req(wdg_rst_req),
    .mode(mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_ce(input int n, output int c_cpu, output int c_per);
    c_cpu = 0;
    c_per = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c_cpu += int'(cpu_ce);
      c_per += int'(per_ce);
    end
  endtask

  task automatic settle();
    repeat (70) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int c_cpu, c_per, n, bad_cpu, bad_osc, bad_mode;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state (sampled after the reset edges)
    chk("R1 mode", mode, 0);
    chk("R1 osc_en", osc_en, 1);
    chk("R1 pulses", {wake_req, wdg_rst_req, imask_force}, 0);

    // R2 / R3 divider table
    foreach (VEC[k]) begin
      pll_on = VEC[k].pll; slow_en = VEC[k].slow; div_sel = VEC[k].sel;
      settle();
      count_ce(WIN, c_cpu, c_per);
      chk(VEC[k].slow ? "R3 cpu rate" : "R2 cpu rate", c_cpu, WIN / int'(VEC[k].per));
      chk(VEC[k].slow ? "R3 per rate" : "R2 per rate", c_per, WIN / int'(VEC[k].per));
      chk(VEC[k].slow ? "R3 mode" : "R2 mode", mode, int'(VEC[k].slow));
    end

    // R4 / R5 Wait
    pll_on = 1'b0; slow_en = 1'b0; div_sel = 2'd0; settle();
    wfi = 1'b1; @(negedge clk); wfi = 1'b0;
    chk("R4 wait mode", mode, 2);
    chk("R5 imask_force wait", imask_force, 1);
    chk("R5 imask_val", imask_val, 2);
    count_ce(WIN, c_cpu, c_per);
    chk("R4 cpu stopped", c_cpu, 0);
    chk("R4 per running", c_per, WIN / 4);
    irq_any = 1'b1; @(negedge clk); irq_any = 1'b0;
    chk("R11 wake wait", wake_req, 1);
    chk("R11 run after wait", mode, 0);
    @(negedge clk);
    chk("R11 wake one cycle", wake_req, 0);

    // R4 Slow-Wait, R11 rtc wake
    slow_en = 1'b1; settle();
    wfi = 1'b1; @(negedge clk); wfi = 1'b0;
    chk("R4 slow-wait mode", mode, 3);
    count_ce(WIN, c_cpu, c_per);
    chk("R4 slow-wait cpu", c_cpu, 0);
    chk("R4 slow-wait per", c_per, WIN / 8);
    rtc_tick = 1'b1; @(negedge clk); rtc_tick = 1'b0;
    chk("R11 rtc wake", wake_req, 1);
    chk("R11 slow after wake", mode, 1);
    slow_en = 1'b0; settle();

    // R6 Active-Halt with watchdog active, R11 css wake
    osc_irq_en = 1'b1; wdg_active = 1'b1; wdg_halt_opt = 1'b1;
    halt = 1'b1; @(negedge clk); halt = 1'b0;
    chk("R6 ahalt mode", mode, 4);
    chk("R6 no wdg reset", wdg_rst_req, 0);
    chk("R5 imask_force ahalt", imask_force, 1);
    count_ce(32, c_cpu, c_per);
    chk("R6 clocks stopped", c_cpu + c_per, 0);
    chk("R6 osc on", osc_en, 1);
    css_evt = 1'b1; @(negedge clk); css_evt = 1'b0;
    chk("R11 css wake", wake_req, 1);
    chk("R11 run after ahalt", mode, 0);

    // R10 watchdog-halt reset
    osc_irq_en = 1'b0; settle();
    halt = 1'b1; @(negedge clk); halt = 1'b0;
    chk("R10 wdg req", wdg_rst_req, 1);
    chk("R10 stays run", mode, 0);
    chk("R10 no mask force", imask_force, 0);
    count_ce(WIN, c_cpu, c_per);
    chk("R10 cpu running", c_cpu, WIN / 4);
    chk("R10 osc on", osc_en, 1);

    // R7 / R8 / R9 Halt
    wdg_halt_opt = 1'b0;
    halt = 1'b1; @(negedge clk); halt = 1'b0;
    chk("R7 halt mode", mode, 5);
    chk("R7 osc off", osc_en, 0);
    chk("R5 imask_force halt", imask_force, 1);
    count_ce(32, c_cpu, c_per);
    chk("R7 clocks stopped", c_cpu + c_per, 0);
    irq_any = 1'b1; @(negedge clk); irq_any = 1'b0;
    rtc_tick = 1'b1; @(negedge clk); rtc_tick = 1'b0;
    css_evt = 1'b1; @(negedge clk); css_evt = 1'b0;
    halt = 1'b1; @(negedge clk); halt = 1'b0;
    @(negedge clk);
    chk("R8 still halt", mode, 5);
    chk("R8 osc still off", osc_en, 0);
    chk("R8 no wake", wake_req, 0);
    halt_exit_irq = 1'b1;
    n = 0; bad_cpu = 0; bad_osc = 0; bad_mode = 0;
    do begin
      @(negedge clk);
      halt_exit_irq = 1'b0;
      n++;
      if (!wake_req) begin
        bad_cpu  += int'(cpu_ce | per_ce);
        bad_osc  += int'(!osc_en);
        bad_mode += int'(mode != 3'd5);
      end
    end while (!wake_req && n < 2 * STAB);
    chk("R9 wake delay", n, STAB + 1);
    chk("R9 clocks held", bad_cpu, 0);
    chk("R9 osc restarted", bad_osc, 0);
    chk("R9 mode held", bad_mode, 0);
    chk("R9 run after stab", mode, 0);

    // R12 halt wins over wfi
    osc_irq_en = 1'b1; settle();
    halt = 1'b1; wfi = 1'b1; @(negedge clk); halt = 1'b0; wfi = 1'b0;
    chk("R12 halt priority", mode, 4);
    halt_exit_irq = 1'b1; @(negedge clk); halt_exit_irq = 1'b0;
    chk("R11 exit irq wakes ahalt", mode, 0);

    // R1 reset out of Halt
    osc_irq_en = 1'b0; wdg_active = 1'b0;
    halt = 1'b1; @(negedge clk); halt = 1'b0;
    chk("R7 halt again", mode, 5);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R1 reset from halt mode", mode, 0);
    chk("R1 reset from halt osc", osc_en, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule